// File: doc/BRIEF.md
# Pipe FIFO DMA Request Controller

This block lets an external DMA controller fill a USB pipe's transmit buffer without the CPU writing each word. A write to the select register picks the target pipe, the width of each DMA access and that pipe's maximum packet size. While the chosen pipe has an empty buffer on offer from the packet engine, the block raises a DMA request. Every acknowledged access is passed to the buffer write path at the next free byte offset, and the offset advances by the access width.

A buffer is handed to the packet engine as ready to send in two cases. The first is when it fills to the maximum packet size. The second is when the DMA controller flags an access as its last by asserting the transfer-end input. In that second case a short final packet goes out with no software step. After a hand-off the request stays low. The packet engine must then withdraw the buffer-available flag for that pipe and offer a new empty buffer before the request returns.

Top module: `pdma_port_ctrl`

## Requirements
- R1: While reset is held and after its release, `dma_req`, `buf_we` and `pkt_ready` are 0, and the selected pipe is 0.
- R2: `dma_req` is high only when three conditions hold: the selected pipe is 1 to 9, its `buf_avail` bit is 1, and the block is not waiting for that buffer to be withdrawn. Pipe 0 and the values 10 to 15 never raise it.
- R3: Width code 00 gives 1 byte per access with `buf_be`=0001. Code 01 gives 2 bytes with `buf_be`=0011. Code 10 gives 4 bytes with `buf_be`=1111. The reserved code 11 acts as 00.
- R4: An access is accepted only in a cycle where `dma_req` and `dma_ack` are both high. In that cycle `buf_we` is 1, `buf_addr` is the byte count before the access, `buf_pipe` is the selected pipe and `buf_wdata` is `dma_wdata`. An `dma_ack` while `dma_req` is low writes nothing and leaves the count unchanged.
- R5: When an accepted access brings the count to the maximum packet size or beyond, `pkt_ready` is 1 for exactly one cycle, in the cycle after that access. In that cycle `pkt_bytes` holds the new count and `pkt_pipe` the pipe. `dma_req` is 0 from that cycle on, and the count restarts at 0.
- R6: `dma_end` high during an accepted access closes the buffer in the same way as R5, with the partial byte count.
- R7: `dma_end` on an access that exactly fills the buffer yields a single packet of full size. No zero-length packet follows.
- R8: A select-register write is ignored while the byte count is non-zero or while an access is being accepted in the same cycle.
- R9: After a hand-off, `dma_req` stays 0 until `buf_avail` of the selected pipe has been seen 0 and then 1 again. A pipe change also clears the wait. The next buffer starts at `buf_addr`=0.
- R10: `dma_req` follows a falling `buf_avail` bit in the same cycle. An `dma_ack` held during that gap is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Select-register write strobe |
| cfg_pipe | input | 4 | Target pipe number |
| cfg_width | input | 2 | Access width code |
| cfg_mps | input | 11 | Maximum packet size in bytes |
| buf_avail | input | 10 | Per pipe: an empty buffer is offered to the CPU side |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge, one access |
| dma_end | input | 1 | Marks the acknowledged access as the transfer's last |
| dma_wdata | input | 32 | DMA write data, lane 0 in the low byte |
| buf_we | output | 1 | Buffer write strobe |
| buf_pipe | output | 4 | Pipe whose buffer is written |
| buf_addr | output | 11 | Byte offset in the buffer |
| buf_be | output | 4 | Byte enables |
| buf_wdata | output | 32 | Buffer write data |
| pkt_ready | output | 1 | One-cycle pulse: the buffer is ready to send |
| pkt_pipe | output | 4 | Pipe of the handed-off buffer |
| pkt_bytes | output | 11 | Byte count of the handed-off buffer |

## Verification
Two collisions matter here. The first is a select-register write in the very cycle the first access of a new buffer is accepted. The bench raises `cfg_we` together with `dma_ack` while the count is still 0. It then judges from the later `buf_pipe` values and the packet log that the pipe did not change. The second is a transfer end on the access that also fills the buffer. The bench has the last 2-byte access of an 8-byte packet carry `dma_end`, and it checks that exactly one 8-byte packet and no zero-length packet appear in the log.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [1:0] {
        WID_8   = 2'b00,
        WID_16  = 2'b01,
        WID_32  = 2'b10,
        WID_RSV = 2'b11
    } width_e;

    function automatic logic [2:0] width_bytes(width_e w);
        case (w)
            WID_16:  return 3'd2;
            WID_32:  return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/pdma_width_dec.sv
module pdma_width_dec
    import pdma_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  width_e          width,
    output logic [2:0]      step,
    output logic [BE_W-1:0] be
);
    assign step = width_bytes(width);

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign be[g] = (g < int'(step));
    end
endmodule

// File: rtl/pdma_pipe_gate.sv
module pdma_pipe_gate #(
    parameter int NUM_PIPES = 10,
    parameter int PIPE_W    = 4
) (
    input  logic [PIPE_W-1:0]    sel,
    input  logic [NUM_PIPES-1:0] avail,
    input  logic                 waiting,
    output logic                 sel_avail,
    output logic                 req
);
    logic [NUM_PIPES-1:0] hit;

    // pipe 0 is the control pipe and never takes part
    assign hit[0] = 1'b0;
    for (genvar g = 1; g < NUM_PIPES; g++) begin : g_pipe
        assign hit[g] = (sel == PIPE_W'(g)) && avail[g];
    end

    assign sel_avail = |hit;
    assign req       = sel_avail && !waiting;
endmodule

// File: rtl/pdma_port_ctrl.sv
module pdma_port_ctrl
    import pdma_pkg::*;
#(
    parameter int NUM_PIPES = 10,
    parameter int PIPE_W    = 4,
    parameter int CNT_W     = 11,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [PIPE_W-1:0]    cfg_pipe,
    input  logic [1:0]           cfg_width,
    input  logic [CNT_W-1:0]     cfg_mps,
    input  logic [NUM_PIPES-1:0] buf_avail,
    output logic                 dma_req,
    input  logic                 dma_ack,
    input  logic                 dma_end,
    input  logic [DATA_W-1:0]    dma_wdata,
    output logic                 buf_we,
    output logic [PIPE_W-1:0]    buf_pipe,
    output logic [CNT_W-1:0]     buf_addr,
    output logic [DATA_W/8-1:0]  buf_be,
    output logic [DATA_W-1:0]    buf_wdata,
    output logic                 pkt_ready,
    output logic [PIPE_W-1:0]    pkt_pipe,
    output logic [CNT_W-1:0]     pkt_bytes
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
        width_e            width;
        logic [CNT_W-1:0]  mps;
        logic [CNT_W-1:0]  cnt;
        logic              waiting;
        logic              ready;
        logic [CNT_W-1:0]  bytes;
    } state_t;

    state_t st_d, st_q;

    logic            sel_avail;
    logic            accept;
    logic [2:0]      step;
    logic [CNT_W:0]  sum;

    pdma_width_dec #(.BE_W(BE_W)) i_wdec (
        .width (st_q.width),
        .step  (step),
        .be    (buf_be)
    );

    pdma_pipe_gate #(.NUM_PIPES(NUM_PIPES), .PIPE_W(PIPE_W)) i_gate (
        .sel       (st_q.pipe),
        .avail     (buf_avail),
        .waiting   (st_q.waiting),
        .sel_avail (sel_avail),
        .req       (dma_req)
    );

    assign accept = dma_req && dma_ack;
    assign sum    = {1'b0, st_q.cnt} + (CNT_W+1)'(step);

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        if (accept) begin
            if (dma_end || (sum >= {1'b0, st_q.mps})) begin
                // hand the buffer over, full or cut short
                st_d.ready   = 1'b1;
                st_d.bytes   = sum[CNT_W-1:0];
                st_d.cnt     = '0;
                st_d.waiting = 1'b1;
            end else begin
                st_d.cnt = sum[CNT_W-1:0];
            end
        end else if (st_q.waiting && !sel_avail) begin
            // the engine has taken the buffer back
            st_d.waiting = 1'b0;
        end
        if (cfg_we && (st_q.cnt == '0) && !accept) begin
            if (cfg_pipe != st_q.pipe) begin
                st_d.waiting = 1'b0;
            end
            st_d.pipe  = cfg_pipe;
            st_d.width = width_e'(cfg_width);
            st_d.mps   = cfg_mps;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pipe: '0, width: WID_8, mps: '0, cnt: '0,
                      waiting: 1'b0, ready: 1'b0, bytes: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_we    = accept;
    assign buf_pipe  = st_q.pipe;
    assign buf_addr  = st_q.cnt;
    assign buf_wdata = dma_wdata;
    assign pkt_ready = st_q.ready;
    assign pkt_pipe  = st_q.pipe;
    assign pkt_bytes = st_q.bytes;
endmodule

// File: rtl/pdma_port_chk.sv
module pdma_port_chk #(
    parameter int NUM_PIPES = 10,
    parameter int PIPE_W    = 4,
    parameter int CNT_W     = 11,
    parameter int BE_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PIPE_W-1:0] sel,
    input logic              dma_req,
    input logic              buf_we,
    input logic [CNT_W-1:0]  buf_addr,
    input logic [BE_W-1:0]   buf_be,
    input logic              pkt_ready,
    input logic [CNT_W-1:0]  pkt_bytes
);
    // R2
    req_pipe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (sel != '0) && (int'(sel) < NUM_PIPES));

    // R3
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $onehot({1'b0, buf_be} + 1'b1));

    // R5
    ready_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> $past(buf_we));

    // R5
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |=> !pkt_ready);

    // R5
    req_low_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> !dma_req);

    // R7
    no_empty_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (pkt_bytes != '0));

    // R8
    pipe_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_addr != '0) |=> $stable(sel));
endmodule

bind pdma_port_ctrl pdma_port_chk #(
    .NUM_PIPES (NUM_PIPES),
    .PIPE_W    (PIPE_W),
    .CNT_W     (CNT_W),
    .BE_W      (DATA_W/8)
) i_pdma_port_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (st_q.pipe),
    .dma_req   (dma_req),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_be    (buf_be),
    .pkt_ready (pkt_ready),
    .pkt_bytes (pkt_bytes)
);

// File: tb/test_pdma_port_ctrl.sv
module test_pdma_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_pipe = '0;
    logic [1:0]  cfg_width = '0;
    logic [10:0] cfg_mps = '0;
    logic [9:0]  buf_avail = '0;
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic        dma_end = 1'b0;
    logic [31:0] dma_wdata = '0;
    logic        buf_we;
    logic [3:0]  buf_pipe;
    logic [10:0] buf_addr;
    logic [3:0]  buf_be;
    logic [31:0] buf_wdata;
    logic        pkt_ready;
    logic [3:0]  pkt_pipe;
    logic [10:0] pkt_bytes;

    int tests = 0;
    int fails = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_pipe, m_width, m_mps, m_cnt, m_ready, m_bytes, m_ppipe;
    bit m_wait;
    int pkt_log[$];
    int pkt_exp[$];

    always #4 clk = ~clk;

    pdma_port_ctrl i_pdma_port_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pipe(cfg_pipe),
        .cfg_width(cfg_width), .cfg_mps(cfg_mps), .buf_avail(buf_avail),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_end(dma_end),
        .dma_wdata(dma_wdata), .buf_we(buf_we), .buf_pipe(buf_pipe),
        .buf_addr(buf_addr), .buf_be(buf_be), .buf_wdata(buf_wdata),
        .pkt_ready(pkt_ready), .pkt_pipe(pkt_pipe), .pkt_bytes(pkt_bytes)
    );

    function automatic int step_of(int w);
        return (w == 1) ? 2 : (w == 2) ? 4 : 1;
    endfunction

    function automatic bit m_req();
        if (m_pipe < 1 || m_pipe > 9) return 1'b0;
        return buf_avail[m_pipe] && !m_wait;
    endfunction

    function automatic bit m_avail();
        if (m_pipe < 1 || m_pipe > 9) return 1'b0;
        return buf_avail[m_pipe];
    endfunction

    always @(posedge clk) begin
        bit acc;
        int n;
        if (!rst_n) begin
            m_pipe = 0; m_width = 0; m_mps = 0; m_cnt = 0;
            m_wait = 1'b0; m_ready = 0; m_bytes = 0; m_ppipe = 0;
        end else begin
            acc = m_req() && dma_ack;
            m_ready = 0;
            if (acc) begin
                n = m_cnt + step_of(m_width);
                if (dma_end || n >= m_mps) begin
                    m_ready = 1; m_bytes = n; m_ppipe = m_pipe;
                    m_cnt = 0; m_wait = 1'b1;
                end else begin
                    m_cnt = n;
                end
            end else if (m_wait && !m_avail()) begin
                m_wait = 1'b0;
            end
            if (cfg_we && m_cnt == 0 && !acc) begin
                if (int'(cfg_pipe) != m_pipe) m_wait = 1'b0;
                m_pipe = int'(cfg_pipe);
                m_width = int'(cfg_width);
                m_mps = int'(cfg_mps);
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare against the model away from the active edge
    always @(negedge clk) begin
        bit er;
        int eb;
        if (running) begin
            er = m_req();
            check(dma_req == er, "R2 R9 R10", "dma_req", int'(dma_req), int'(er));
            check(buf_we == (er && dma_ack), "R4", "buf_we", int'(buf_we), int'(er && dma_ack));
            if (buf_we && er) begin
                eb = (1 << step_of(m_width)) - 1;
                check(int'(buf_addr) == m_cnt, "R4", "buf_addr", int'(buf_addr), m_cnt);
                check(int'(buf_pipe) == m_pipe, "R4", "buf_pipe", int'(buf_pipe), m_pipe);
                check(buf_wdata == dma_wdata, "R4", "buf_wdata", int'(buf_wdata), int'(dma_wdata));
                check(int'(buf_be) == eb, "R3", "buf_be", int'(buf_be), eb);
            end
            check(int'(pkt_ready) == m_ready, "R5 R6", "pkt_ready", int'(pkt_ready), m_ready);
            if (pkt_ready && m_ready == 1) begin
                check(int'(pkt_bytes) == m_bytes, "R5 R6", "pkt_bytes", int'(pkt_bytes), m_bytes);
                check(int'(pkt_pipe) == m_ppipe, "R5", "pkt_pipe", int'(pkt_pipe), m_ppipe);
            end
            if (pkt_ready) pkt_log.push_back(int'(pkt_pipe) * 4096 + int'(pkt_bytes));
        end
    end

    task automatic cfg(int p, int w, int m);
        cfg_we = 1'b1; cfg_pipe = 4'(p); cfg_width = 2'(w); cfg_mps = 11'(m);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic dma_wr(logic [31:0] d, bit last);
        dma_ack = 1'b1; dma_wdata = d; dma_end = last;
        do @(negedge clk); while (!dma_req);
        @(posedge clk); #1;
        dma_ack = 1'b0; dma_end = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 outputs quiet in reset
        check(!dma_req && !buf_we && !pkt_ready, "R1", "outputs in reset",
              int'({dma_req, buf_we, pkt_ready}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        running = 1'b1;
        buf_avail = 10'h3FF;
        idle(1);
        check(!dma_req, "R1", "dma_req after reset", int'(dma_req), 0);

        // R2 control pipe and out-of-range pipe never request
        cfg(0, 2, 16);
        check(!dma_req, "R2", "pipe 0 request", int'(dma_req), 0);
        cfg(10, 2, 16);
        check(!dma_req, "R2", "pipe 10 request", int'(dma_req), 0);

        // R5 full packet, 32-bit accesses
        cfg(3, 2, 16);
        for (int i = 0; i < 4; i++) dma_wr(32'hA000_0000 + i, 1'b0);
        pkt_exp.push_back(3 * 4096 + 16);
        idle(3);
        // R9 no new request until the buffer is withdrawn and offered again
        check(!dma_req, "R9", "request while handed off", int'(dma_req), 0);
        buf_avail[3] = 1'b0; idle(1);
        buf_avail[3] = 1'b1; idle(1);
        check(dma_req, "R9", "request on new buffer", int'(dma_req), 1);

        // R6 early end, with a pipe change attempted mid-transfer (R8)
        dma_wr(32'hB1, 1'b0);
        cfg(5, 0, 64);
        dma_wr(32'hB2, 1'b0);
        dma_wr(32'hB3, 1'b1);
        pkt_exp.push_back(3 * 4096 + 12);
        idle(2);
        buf_avail[3] = 1'b0; idle(1);
        buf_avail[3] = 1'b1;

        // R7 end flag on the filling access, 16-bit accesses
        cfg(7, 1, 8);
        for (int i = 0; i < 4; i++) dma_wr(32'hC000 + i, i == 3);
        pkt_exp.push_back(7 * 4096 + 8);
        idle(4);

        // R4 acknowledge without request is ignored
        buf_avail[9] = 1'b0;
        cfg(9, 0, 4);
        dma_ack = 1'b1; idle(2);
        dma_ack = 1'b0; idle(1);
        buf_avail[9] = 1'b1; idle(1);
        // R8 select write colliding with the first accepted access
        cfg_we = 1'b1; cfg_pipe = 4'd2; cfg_width = 2'd2; cfg_mps = 11'd32;
        dma_ack = 1'b1; dma_wdata = 32'hD1;
        do @(negedge clk); while (!dma_req);
        @(posedge clk); #1;
        cfg_we = 1'b0; dma_ack = 1'b0;
        // R10 request falls with the buffer flag, ack ignored meanwhile
        buf_avail[9] = 1'b0; dma_ack = 1'b1;
        @(negedge clk);
        check(!dma_req && !buf_we, "R10", "request with buffer gone",
              int'({dma_req, buf_we}), 0);
        idle(1);
        dma_ack = 1'b0;
        buf_avail[9] = 1'b1;
        dma_wr(32'hD2, 1'b1);
        @(negedge clk);
        check(buf_pipe == 4'd9, "R8", "pipe after collided write", int'(buf_pipe), 9);
        pkt_exp.push_back(9 * 4096 + 2);
        idle(4);

        check(pkt_log.size() == pkt_exp.size(), "R7", "packet count",
              pkt_log.size(), pkt_exp.size());
        for (int i = 0; i < pkt_exp.size(); i++) begin
            if (i < pkt_log.size())
                check(pkt_log[i] == pkt_exp[i], "R5 R6 R7", "packet pipe*4096+bytes",
                      pkt_log[i], pkt_exp[i]);
        end
        done = 1'b1;
        finish_run();
    end
endmodule